// File: doc/BRIEF.md
# Two-Dimensional 8x8 Inverse DCT Engine

This block turns one 8x8 block of dequantised frequency amplitudes into 64 spatial pixel values. A host streams the 64 amplitudes in through a valid/ready load port. The engine then runs two one-dimensional 8-point inverse transforms, first over the rows and then over the columns. Each 1D output sample is produced in a single clock. Eight parallel multiply lanes weight the eight operands with cosine coefficients held inside the block, and an adder tree sums the products.

The row pass writes its rounded 16-bit results into a 64-entry transpose store. The column pass reads that store along its rows, which are the columns of the intermediate block. Each pass takes 65 clocks: 64 issue cycles and one drain cycle. A whole block therefore takes 130 clocks after loading ends. The column results are rounded, shifted up by 128 and clamped to an 8-bit pixel by a purely combinational output stage. Each pixel is presented with a valid flag and its position in the block.

Top module: `idct2d_engine`

## Requirements
- R1: While `in_ready` is high, the engine accepts a 12-bit two's-complement amplitude on each rising edge where `in_valid` is high. Cycles without `in_valid` are skipped. Amplitude number `r*8+k` is frequency `k` of row `r`, and the 64th accepted amplitude completes the load.
- R2: `busy` is high from the edge after the first accepted amplitude until the last pixel has been output. While the block is being computed, `in_ready` is low and `in_valid` has no effect on the results or on the next block.
- R3: The cosine weight of frequency `k` for spatial position `n` is round(4096·a(k)·cos((2n+1)kπ/16)). Here a(0)=1/(2√2) and a(k)=1/2 for k≥1.
- R4: The row pass forms, for each row `r` and position `n`, the sum over `k` of weight(k,n)·amplitude(r,k). It then adds 2048, shifts arithmetically right by 12, and keeps the value as a 16-bit signed intermediate at row `r`, column `n`.
- R5: The column pass applies the same weighted sum and rounding down each column of the intermediate block. With the level shift enabled (default), it adds 128 and clamps the pixel to 0..255.
- R6: The first pixel is valid 66 rising edges after the edge that accepted the 64th amplitude. The 64 pixels follow on consecutive cycles, so the last is valid 129 edges after that edge. After edge 130, `busy` is low and `in_ready` is high.
- R7: `out_idx` is row·8+column of the pixel. Pixels leave column by column, rows 0 to 7 within each column, so the k-th pixel of a block has index (k mod 8)·8 + k/8.
- R8: A block whose only non-zero amplitude is frequency (0,0) of row 0 yields 64 equal pixels. For DC values 0, 64 and 1000, the pixels are 128, 136 and 253.
- R9: Pixels clamp at both ends of the range. A DC-only block of 2047 gives 255 everywhere, and DC-only blocks of −1024 and −2048 give 0 everywhere.
- R10: While `rst` is high and in the cycle after it falls, `out_valid` and `busy` are low and `in_ready` is high. A partially loaded block is discarded by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Amplitude on `in_data` is offered |
| in_ready | output | 1 | Engine can accept an amplitude |
| in_data | input | 12 | Signed amplitude, row-major frequency order |
| busy | output | 1 | A block is being loaded or transformed |
| out_valid | output | 1 | `out_pix` and `out_idx` hold a pixel |
| out_pix | output | 8 | Pixel after rounding, level shift and clamping |
| out_idx | output | 6 | Position of the pixel, row·8+column |

## Verification
Every pixel of a block is due at a fixed offset from the edge that accepted the final amplitude. The first is due 66 edges later, the last 129 edges later, and `busy` clears after edge 130. The bench counts rising edges, notes that count when loading completes, and compares the edge numbers of the first and last valid pixel and of the ready return against those offsets. All outputs are sampled on the falling edge, half a period after the register that drives them has updated. Pixel values are compared by index against a reference built from the cosine formula with real arithmetic, so the stream order is checked separately against the sequence of R7.

// File: rtl/idct_pkg.sv
package idct_pkg;

    localparam int N      = 8;             // points per 1D transform
    localparam int NN     = N * N;         // samples per block
    localparam int MID_W  = 16;            // intermediate word
    localparam int COEF_W = 13;            // signed weight word
    localparam int FRAC   = 12;            // fractional bits of weights
    localparam int ACC_W  = 32;            // product and sum word
    localparam int IDX_W  = $clog2(NN);
    localparam int CNT_W  = $clog2(NN + 1);
    localparam int POS_W  = $clog2(N);
    localparam int PIX_W  = 8;

    typedef logic signed [MID_W-1:0]  mid_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef enum logic [1:0] {PH_LOAD, PH_ROWS, PH_COLS} phase_e;

    typedef struct packed {
        logic             vld;
        logic             pass2;
        logic [IDX_W-1:0] idx;
        acc_t             sum;
    } stage_t;

    // 2048 * cos(m*pi/16) for m = 0..8, rounded
    function automatic coef_t cos_q(input int m);
        case (m)
            0:       return coef_t'(2048);
            1:       return coef_t'(2009);
            2:       return coef_t'(1892);
            3:       return coef_t'(1703);
            4:       return coef_t'(1448);
            5:       return coef_t'(1138);
            6:       return coef_t'(784);
            7:       return coef_t'(400);
            default: return coef_t'(0);
        endcase
    endfunction

    // weight of frequency k at spatial position n, 12 fractional bits
    function automatic coef_t weight(input int k, input int n);
        int m;
        if (k == 0) return coef_t'(1448);
        m = ((2 * n + 1) * k) % 32;
        if (m > 16) m = 32 - m;
        if (m > 8) return -cos_q(16 - m);
        return cos_q(m);
    endfunction

    function automatic acc_t round_q(input acc_t a);
        return (a + acc_t'(2 ** (FRAC - 1))) >>> FRAC;
    endfunction

endpackage

// File: rtl/idct_mac8.sv
module idct_mac8 import idct_pkg::*; (
    input  mid_t             opnd [N],
    input  logic [POS_W-1:0] col,
    output acc_t             sum
);
    localparam int H1 = N / 2;
    localparam int H2 = N / 4;

    acc_t prod [N];
    acc_t lvl1 [H1];
    acc_t lvl2 [H2];

    for (genvar k = 0; k < N; k++) begin : g_lane
        always_comb prod[k] = acc_t'(opnd[k]) * acc_t'(weight(k, int'(col)));
    end

    for (genvar i = 0; i < H1; i++) begin : g_add1
        assign lvl1[i] = prod[2*i] + prod[2*i+1];
    end

    for (genvar i = 0; i < H2; i++) begin : g_add2
        assign lvl2[i] = lvl1[2*i] + lvl1[2*i+1];
    end

    assign sum = lvl2[0] + lvl2[1];

endmodule

// File: rtl/idct_pixel.sv
module idct_pixel import idct_pkg::*; #(
    parameter bit LEVEL_SHIFT = 1'b1
) (
    input  acc_t             sum,
    output logic [PIX_W-1:0] pix
);
    acc_t v;

    always_comb begin
        v = round_q(sum);
        if (LEVEL_SHIFT) begin
            v = v + acc_t'(128);
            if (v < 0)                 pix = '0;
            else if (v > acc_t'(255))  pix = '1;
            else                       pix = v[PIX_W-1:0];
        end else begin
            if (v < acc_t'(-128))      pix = 8'h80;
            else if (v > acc_t'(127))  pix = 8'h7f;
            else                       pix = v[PIX_W-1:0];
        end
    end

endmodule

// File: rtl/idct2d_engine.sv
module idct2d_engine import idct_pkg::*; #(
    parameter int AMP_W       = 12,
    parameter bit LEVEL_SHIFT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [AMP_W-1:0] in_data,
    output logic             busy,
    output logic             out_valid,
    output logic [PIX_W-1:0] out_pix,
    output logic [IDX_W-1:0] out_idx
);
    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    stage_t           st;

    mid_t ablk [NN];   // loaded amplitudes, row-major
    mid_t tblk [NN];   // row-pass results, stored transposed

    logic [POS_W-1:0] line, pos;
    logic             issue;
    mid_t             opnd [N];
    acc_t             mac_sum;

    assign line  = cnt[2*POS_W-1:POS_W];
    assign pos   = cnt[POS_W-1:0];
    assign issue = (phase != PH_LOAD) && !cnt[CNT_W-1];

    for (genvar k = 0; k < N; k++) begin : g_opnd
        always_comb opnd[k] = (phase == PH_COLS) ? tblk[{line, POS_W'(k)}]
                                                 : ablk[{line, POS_W'(k)}];
    end

    idct_mac8 u_mac (
        .opnd (opnd),
        .col  (pos),
        .sum  (mac_sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_LOAD;
            cnt   <= '0;
            st    <= '0;
        end else begin
            st.vld   <= issue;
            st.pass2 <= (phase == PH_COLS);
            st.idx   <= {pos, line};
            st.sum   <= mac_sum;
            case (phase)
                PH_LOAD: if (in_valid) begin
                    if (cnt == CNT_W'(NN - 1)) begin
                        phase <= PH_ROWS;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_ROWS: if (cnt == CNT_W'(NN)) begin
                    phase <= PH_COLS;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: if (cnt == CNT_W'(NN)) begin
                    phase <= PH_LOAD;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (phase == PH_LOAD && in_valid)
            ablk[cnt[IDX_W-1:0]] <= mid_t'(signed'(in_data));
    end

    always_ff @(posedge clk) begin
        if (st.vld && !st.pass2)
            tblk[st.idx] <= mid_t'(round_q(st.sum));
    end

    idct_pixel #(.LEVEL_SHIFT(LEVEL_SHIFT)) u_pix (
        .sum (st.sum),
        .pix (out_pix)
    );

    assign in_ready  = (phase == PH_LOAD);
    assign busy      = (phase != PH_LOAD) || (cnt != '0);
    assign out_valid = st.vld && st.pass2;
    assign out_idx   = st.idx;

endmodule

// File: rtl/idct2d_engine_chk.sv
module idct2d_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_ready,
    input logic       busy,
    input logic       out_valid,
    input logic [5:0] out_idx
);
    logic [6:0] n_out;

    always_ff @(posedge clk) begin
        if (rst)            n_out <= '0;
        else if (out_valid) n_out <= n_out + 1'b1;
        else if (!busy)     n_out <= '0;
    end

    AST_NO_LOAD_DURING_OUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R2

    AST_BUSY_COVERS_OUT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy); // R2

    AST_IDX_ORDER: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(out_valid) |->
            out_idx == (($past(out_idx) >= 6'd56) ? $past(out_idx) - 6'd55
                                                  : $past(out_idx) + 6'd8)); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        n_out <= 7'd64); // R6

    AST_BLOCK_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(out_valid) |-> (n_out == 7'd64) && !busy); // R6

endmodule

bind idct2d_engine idct2d_engine_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .busy      (busy),
    .out_valid (out_valid),
    .out_idx   (out_idx)
);

// File: tb/idct2d_engine_test.sv
module idct2d_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] in_data = '0;
    logic        in_ready, busy, out_valid;
    logic [7:0]  out_pix;
    logic [5:0]  out_idx;

    idct2d_engine uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .busy(busy), .out_valid(out_valid),
        .out_pix(out_pix), .out_idx(out_idx)
    );

    always #5 clk = ~clk;

    // DC amplitude of row 0, expected flat pixel
    localparam int DC_VEC [6][2] = '{
        '{0, 128}, '{64, 136}, '{1000, 253},
        '{2047, 255}, '{-1024, 0}, '{-2048, 0}
    };

    int     n_chk = 0, n_fail = 0;
    longint cyc = 0;
    int     amp  [64];
    int     expv [64];
    int     got  [64];
    int     seen = 0, order_bad = 0;
    longint first_cyc = 0, last_cyc = 0, acc_cyc = 0;
    bit     done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (seen == 0) first_cyc = cyc;
            if (seen < 64 && int'(out_idx) != ((seen % 8) * 8 + seen / 8)) order_bad++;
            last_cyc = cyc;
            got[out_idx] = int'(out_pix);
            seen++;
        end
    end

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int wt(input int k, input int n);
        real ck, r;
        ck = (k == 0) ? 1.0 / (2.0 * $sqrt(2.0)) : 0.5;
        r  = 4096.0 * ck * $cos(real'((2 * n + 1) * k) * 3.14159265358979 / 16.0);
        return (r >= 0.0) ? int'($floor(r + 0.5)) : -int'($floor(-r + 0.5));
    endfunction

    function automatic longint rnd(input longint a);
        return (a + 2048) >>> 12;
    endfunction

    task automatic build_ref();
        int mid [64];
        for (int r = 0; r < 8; r++)
            for (int n = 0; n < 8; n++) begin
                longint s = 0;
                for (int k = 0; k < 8; k++) s += longint'(wt(k, n)) * amp[r*8+k];
                mid[r*8+n] = int'(rnd(s));
            end
        for (int c = 0; c < 8; c++)
            for (int n = 0; n < 8; n++) begin
                longint s = 0, v;
                for (int k = 0; k < 8; k++) s += longint'(wt(k, n)) * mid[k*8+c];
                v = rnd(s) + 128;
                if (v < 0) v = 0;
                if (v > 255) v = 255;
                expv[n*8+c] = int'(v);
            end
    endtask

    // load amp[], optionally with an idle gap and with in_valid held during compute
    task automatic run_block(input string req, input bit gap, input bit poke);
        seen = 0; order_bad = 0;
        for (int i = 0; i < 64; i++) begin
            if (gap && i == 20) begin
                @(negedge clk); in_valid = 1'b0; in_data = 12'h5a5;
            end
            @(negedge clk);
            in_valid = 1'b1; in_data = 12'(amp[i]);
            if (i == 0 || i == 63) check("R1", "in_ready during load", in_ready, 1);
            if (i == 1) check("R2", "busy after first load", busy, 1);
        end
        @(negedge clk);
        acc_cyc = cyc;
        in_valid = poke; in_data = 12'h7ff;
        check("R2", "in_ready while computing", in_ready, 0);
        check("R2", "busy while computing", busy, 1);
        for (int w = 0; w < 400 && busy; w++) @(negedge clk);
        in_valid = 1'b0;
        check("R6", "busy clear edge", cyc - acc_cyc, 130);
        check("R6", "in_ready back", in_ready, 1);
        check("R6", "pixel count", seen, 64);
        check("R6", "first pixel latency", first_cyc - acc_cyc, 66);
        check("R6", "last pixel latency", last_cyc - acc_cyc, 129);
        check("R7", "index order errors", order_bad, 0);
        for (int p = 0; p < 64; p++) check(req, $sformatf("pixel %0d", p), got[p], expv[p]);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "out_valid in reset", out_valid, 0);
        check("R10", "busy in reset", busy, 0);
        check("R10", "in_ready in reset", in_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        check("R10", "busy after reset", busy, 0);
        check("R10", "out_valid after reset", out_valid, 0);

        // R8, R9: DC-only vector table
        for (int v = 0; v < 6; v++) begin
            foreach (amp[i]) amp[i] = 0;
            amp[0] = DC_VEC[v][0];
            foreach (expv[i]) expv[i] = DC_VEC[v][1];
            run_block((v >= 3) ? "R9" : "R8", 1'b0, 1'b0);
        end

        // R3, R4, R5: mixed spectrum
        foreach (amp[i]) amp[i] = ((i * 37 + 11) % 97 - 48) * ((i % 8 == 0) ? 6 : 2);
        build_ref();
        run_block("R4", 1'b0, 1'b0);

        // R3: isolated AC terms expose weight signs
        foreach (amp[i]) amp[i] = 0;
        amp[1] = 700; amp[8] = -400; amp[9] = 250; amp[63] = -300;
        build_ref();
        run_block("R3", 1'b0, 1'b0);

        // R5: large alternating amplitudes, clamping on both sides
        foreach (amp[i]) amp[i] = ((i % 2) ? -1 : 1) * (2000 - 20 * i);
        build_ref();
        run_block("R5", 1'b0, 1'b0);

        // R1, R2: idle gap in the load and in_valid held during compute
        foreach (amp[i]) amp[i] = ((i * 53 + 7) % 61 - 30) * 3;
        build_ref();
        run_block("R2", 1'b1, 1'b1);
        foreach (amp[i]) amp[i] = (i % 9) * 15 - 60;
        build_ref();
        run_block("R1", 1'b0, 1'b0);

        // R10: reset in the middle of a load discards it
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); in_valid = 1'b1; in_data = 12'h3ff;
        end
        @(negedge clk); in_valid = 1'b0; rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R10", "busy after mid-load reset", busy, 0);
        check("R10", "in_ready after mid-load reset", in_ready, 1);
        foreach (amp[i]) amp[i] = 0;
        amp[0] = 64;
        foreach (expv[i]) expv[i] = 136;
        run_block("R10", 1'b0, 1'b0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule